// File: doc/BRIEF.md
# Ones-Complement Rotating Checksum Engine

This block computes a 16-bit packet checksum over a run of words in memory. Software gives a start address, a word count and an initial partial sum, then pulses `start`. The engine fetches the words one at a time over a simple request/response read port. Each word is folded into the running sum with a ones-complement add: a carry out of the top bit is added back in at the bottom. The sum is then rotated left by one bit. When the last word has been processed, an all-ones result (ones-complement negative zero) is turned into zero, and `done` rises with the checksum on `result`.

The work can be paused at a word boundary with `suspend`. The running sum, the next address and the remaining count are always visible on the `cur_*` outputs. To continue, software starts the engine again with those three values. A fresh computation starts from an initial sum of zero. A nonzero initial sum is only used to resume.

Top module: `cksum_engine`

## Requirements
- R1: A data word d is combined with the partial sum s as follows: take the 17-bit sum s+d, and if bit 16 (the true carry) is set, add 1 to its low 16 bits. A partial sum of zero never produces a carry correction.
- R2: After the carry correction, the 16-bit sum is rotated left by one bit. Bit 15 moves to bit 0.
- R3: Each word costs exactly one read. `mem_req` is a single-cycle pulse and only one read is outstanding at a time. The next request is raised in the cycle after `mem_valid`. Addresses start at the start address and rise by one per word. The exposed count falls by one per word.
- R4: When the count runs out, a final sum of 16'hFFFF is reported as 16'h0000. Every other value is reported unchanged.
- R5: A start with a count of zero issues no read. It raises `done` at the clock edge that accepts the start, with `result` equal to the folded initial sum.
- R6: `done` and `result` stay unchanged until the next accepted start. A start is accepted only while `busy` is low; a start while busy has no effect.
- R7: `suspend` is sampled only when a word's data arrives and words remain. If it is high, the engine stops with `suspended` high, `busy` low and `cur_sum`, `cur_addr`, `cur_count` holding the state after that word. Restarting from these values gives the same result as an uninterrupted run.
- R8: A synchronous active-high `rst` clears `busy`, `done`, `suspended` and `mem_req`.
- R9: `cur_sum`, `cur_addr` and `cur_count` are updated at every processed word and loaded from the inputs on an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken when not busy |
| init_sum | input | DATA_W | Initial partial sum |
| start_addr | input | ADDR_W | First word address |
| word_count | input | CNT_W | Number of words |
| suspend | input | 1 | Pause request, honoured at a word boundary |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | ADDR_W | Read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| busy | output | 1 | Engine running |
| done | output | 1 | Checksum ready |
| suspended | output | 1 | Engine paused mid-block |
| result | output | DATA_W | Final folded checksum |
| cur_sum | output | DATA_W | Live partial sum |
| cur_addr | output | ADDR_W | Next word address |
| cur_count | output | CNT_W | Words remaining |

## Verification
The bench targets the following corner cases:
- A zero partial sum added to 16'hFFFF, where a design that infers a carry would return 16'h0001 rotated instead of zero.
- A real carry case, which exposes a missing end-around add.
- A lone 16'h8000, where a shift in place of a rotate loses the top bit.
- A result of all ones, which must come out as zero.
- Zero-length starts, which must finish without a read.
- A start while busy, which would corrupt a run that does not ignore it.
- A suspension, whose resumed result must match an uninterrupted run; a design that saved the pointer or count one word off would not.

// File: rtl/cksum_pkg.sv
package cksum_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } cksum_state_e;

endpackage

// File: rtl/cksum_step.sv
module cksum_step #(
   parameter int DATA_W    = 16,
   parameter int ADD_STYLE = 0
) (
   input  logic [DATA_W-1:0] sum_in,
   input  logic [DATA_W-1:0] word_in,
   output logic [DATA_W-1:0] sum_out
);

   logic [DATA_W-1:0] corrected;

   generate
      if (ADD_STYLE == 0) begin : g_ripple
         // one wide add, then increment on a true carry (R1)
         logic [DATA_W:0] wide;
         always_comb begin
            wide      = {1'b0, sum_in} + {1'b0, word_in};
            corrected = wide[DATA_W-1:0] + {{(DATA_W-1){1'b0}}, wide[DATA_W]};
         end
      end else begin : g_select
         // both candidates computed in parallel, carry picks one (R1)
         logic [DATA_W:0]   plain;
         logic [DATA_W-1:0] plus_one;
         always_comb begin
            plain     = {1'b0, sum_in} + {1'b0, word_in};
            plus_one  = sum_in + word_in + {{(DATA_W-1){1'b0}}, 1'b1};
            corrected = plain[DATA_W] ? plus_one : plain[DATA_W-1:0];
         end
      end
   endgenerate

   // left rotate by one, MSB wraps into LSB (R2)
   assign sum_out = {corrected[DATA_W-2:0], corrected[DATA_W-1]};

endmodule

// File: rtl/cksum_ctrl.sv
module cksum_ctrl
   import cksum_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic start_cnt_zero,
   input  logic cnt_is_one,
   input  logic suspend,
   input  logic mem_valid,
   output logic load,
   output logic accept,
   output logic fin_zero,
   output logic fin_last,
   output logic mem_req,
   output logic busy,
   output logic done,
   output logic suspended
);

   cksum_state_e state_q, state_d;
   logic         done_d, susp_d;

   always_comb begin
      state_d  = state_q;
      done_d   = done;
      susp_d   = suspended;
      load     = 1'b0;
      accept   = 1'b0;
      fin_zero = 1'b0;
      fin_last = 1'b0;
      mem_req  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               load   = 1'b1;
               susp_d = 1'b0;
               if (start_cnt_zero) begin
                  fin_zero = 1'b1;
                  done_d   = 1'b1;
               end else begin
                  done_d  = 1'b0;
                  state_d = ST_ISSUE;
               end
            end
         end
         ST_ISSUE: begin
            mem_req = 1'b1;
            state_d = ST_WAIT;
         end
         ST_WAIT: begin
            if (mem_valid) begin
               accept = 1'b1;
               if (cnt_is_one) begin
                  fin_last = 1'b1;
                  done_d   = 1'b1;
                  state_d  = ST_IDLE;
               end else if (suspend) begin
                  susp_d  = 1'b1;
                  state_d = ST_IDLE;
               end else begin
                  state_d = ST_ISSUE;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_IDLE;
         done      <= 1'b0;
         suspended <= 1'b0;
      end else begin
         state_q   <= state_d;
         done      <= done_d;
         suspended <= susp_d;
      end
   end

   assign busy = (state_q != ST_IDLE);

   assert_req_pulse_R3 : assert property (@(posedge clk) disable iff (rst)
      mem_req |=> !mem_req);

   assert_zero_count_R5 : assert property (@(posedge clk) disable iff (rst)
      (start && !busy && start_cnt_zero) |=> (!busy && done && !mem_req));

   assert_pause_idle_R7 : assert property (@(posedge clk) disable iff (rst)
      suspended |-> !busy);

endmodule

// File: rtl/cksum_regs.sv
module cksum_regs #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              accept,
   input  logic              fin_zero,
   input  logic              fin_last,
   input  logic [DATA_W-1:0] init_sum,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  word_count,
   input  logic [DATA_W-1:0] next_sum,
   output logic [DATA_W-1:0] cur_sum,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  cur_count,
   output logic [DATA_W-1:0] result,
   output logic              cnt_is_one
);

   localparam logic [DATA_W-1:0] NEG_ZERO = {DATA_W{1'b1}};
   localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
   localparam logic [CNT_W-1:0]  CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [DATA_W-1:0] fin_raw;

   function automatic logic [DATA_W-1:0] fold_nz(input logic [DATA_W-1:0] v);
      return (v == NEG_ZERO) ? '0 : v;
   endfunction

   assign fin_raw    = fin_last ? next_sum : init_sum;
   assign cnt_is_one = (cur_count == CNT_ONE);

   always_ff @(posedge clk) begin
      if (rst) begin
         cur_sum   <= '0;
         cur_addr  <= '0;
         cur_count <= '0;
         result    <= '0;
      end else begin
         if (load) begin
            cur_sum   <= init_sum;
            cur_addr  <= start_addr;
            cur_count <= word_count;
         end else if (accept) begin
            cur_sum   <= next_sum;
            cur_addr  <= cur_addr + ADDR_ONE;
            cur_count <= cur_count - CNT_ONE;
         end
         if (fin_zero || fin_last)
            result <= fold_nz(fin_raw);
      end
   end

   assert_addr_step_R3 : assert property (@(posedge clk) disable iff (rst)
      accept |=> (cur_addr == $past(cur_addr) + ADDR_ONE));

   assert_count_step_R9 : assert property (@(posedge clk) disable iff (rst)
      accept |=> (cur_count == $past(cur_count) - CNT_ONE));

   assert_no_neg_zero_R4 : assert property (@(posedge clk) disable iff (rst)
      (fin_zero || fin_last) |=> (result != NEG_ZERO));

endmodule

// File: rtl/cksum_engine.sv
module cksum_engine #(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 16,
   parameter int ADD_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [DATA_W-1:0] init_sum,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  word_count,
   input  logic              suspend,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_valid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              suspended,
   output logic [DATA_W-1:0] result,
   output logic [DATA_W-1:0] cur_sum,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  cur_count
);

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("cksum_engine: DATA_W must be at least 2");
      end
      if (ADDR_W < 1 || CNT_W < 1) begin : g_bad_width
         $error("cksum_engine: ADDR_W and CNT_W must be positive");
      end
      if (ADD_STYLE != 0 && ADD_STYLE != 1) begin : g_bad_style
         $error("cksum_engine: ADD_STYLE must be 0 or 1");
      end
   endgenerate

   logic              load, accept, fin_zero, fin_last, cnt_is_one;
   logic [DATA_W-1:0] next_sum;

   cksum_step #(.DATA_W(DATA_W), .ADD_STYLE(ADD_STYLE)) u_step (
      .sum_in (cur_sum),
      .word_in(mem_rdata),
      .sum_out(next_sum)
   );

   cksum_ctrl u_ctrl (
      .clk           (clk),
      .rst           (rst),
      .start         (start),
      .start_cnt_zero(word_count == '0),
      .cnt_is_one    (cnt_is_one),
      .suspend       (suspend),
      .mem_valid     (mem_valid),
      .load          (load),
      .accept        (accept),
      .fin_zero      (fin_zero),
      .fin_last      (fin_last),
      .mem_req       (mem_req),
      .busy          (busy),
      .done          (done),
      .suspended     (suspended)
   );

   cksum_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .accept    (accept),
      .fin_zero  (fin_zero),
      .fin_last  (fin_last),
      .init_sum  (init_sum),
      .start_addr(start_addr),
      .word_count(word_count),
      .next_sum  (next_sum),
      .cur_sum   (cur_sum),
      .cur_addr  (cur_addr),
      .cur_count (cur_count),
      .result    (result),
      .cnt_is_one(cnt_is_one)
   );

   assign mem_addr = cur_addr;

   assert_done_hold_R6 : assert property (@(posedge clk) disable iff (rst)
      (done && !start) |=> (done && $stable(result)));

   assert_busy_start_R6 : assert property (@(posedge clk) disable iff (rst)
      (busy && start && !mem_valid) |=> ($stable(cur_count) && $stable(cur_sum)));

endmodule

// File: tb/tb_cksum_engine.sv
module tb_cksum_engine;

   logic        clk = 1'b0;
   logic        rst;
   logic        start, suspend, mem_req, mem_valid;
   logic        busy, done, suspended;
   logic [15:0] init_sum, start_addr, word_count, mem_addr, mem_rdata;
   logic [15:0] result, cur_sum, cur_addr, cur_count;

   int total = 0;
   int bad   = 0;

   logic [15:0] mem     [0:255];
   logic [15:0] req_log [0:1023];
   int          req_cnt;
   logic        pend;
   logic [15:0] paddr;
   int          dly;

   always #5 clk = ~clk;

   cksum_engine dut (
      .clk(clk), .rst(rst), .start(start), .init_sum(init_sum),
      .start_addr(start_addr), .word_count(word_count), .suspend(suspend),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
      .mem_rdata(mem_rdata), .busy(busy), .done(done), .suspended(suspended),
      .result(result), .cur_sum(cur_sum), .cur_addr(cur_addr),
      .cur_count(cur_count)
   );

   // memory responder: data one to three cycles after each request
   always @(posedge clk) begin
      if (rst) begin
         mem_valid <= 1'b0;
         mem_rdata <= '0;
         pend      <= 1'b0;
         req_cnt   <= 0;
         dly       <= 0;
         paddr     <= '0;
      end else begin
         mem_valid <= 1'b0;
         if (mem_req) begin
            pend             <= 1'b1;
            paddr            <= mem_addr;
            dly              <= int'($urandom % 3);
            req_log[req_cnt % 1024] <= mem_addr;
            req_cnt          <= req_cnt + 1;
         end else if (pend) begin
            if (dly == 0) begin
               mem_valid <= 1'b1;
               mem_rdata <= mem[paddr[7:0]];
               pend      <= 1'b0;
            end else begin
               dly <= dly - 1;
            end
         end
      end
   end

   // reference arithmetic from the requirements
   function automatic logic [15:0] ref_word(input logic [15:0] s, input logic [15:0] d);
      logic [16:0] w;
      logic [15:0] c;
      w = {1'b0, s} + {1'b0, d};
      c = w[15:0];
      if (w[16]) c = c + 16'd1;
      return {c[14:0], c[15]};
   endfunction

   function automatic logic [15:0] ref_run(input logic [15:0] s, input logic [15:0] a, input int n);
      logic [15:0] acc;
      acc = s;
      for (int i = 0; i < n; i++) acc = ref_word(acc, mem[8'(a + 16'(i))]);
      return acc;
   endfunction

   function automatic logic [15:0] ref_fold(input logic [15:0] v);
      return (v == 16'hFFFF) ? 16'h0000 : v;
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic kick(input logic [15:0] s, input logic [15:0] a, input logic [15:0] n);
      @(negedge clk);
      init_sum = s; start_addr = a; word_count = n; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_stop();
      int t = 0;
      while (!(done || suspended) && t < 2000) begin
         @(negedge clk);
         t++;
      end
      if (t >= 2000) check("watchdog", 16'd1, 16'd0);
   endtask

   task automatic run_check(input string req, input logic [15:0] s, input logic [15:0] a, input int n);
      int base;
      int addr_bad;
      base = req_cnt;
      kick(s, a, 16'(n));
      wait_stop();
      check(req, result, ref_fold(ref_run(s, a, n)));
      check("R3 reads", 16'(req_cnt - base), 16'(n));
      addr_bad = 0;
      for (int i = 0; i < n; i++)
         if (req_log[(base + i) % 1024] !== a + 16'(i)) addr_bad++;
      check("R3 addr", 16'(addr_bad), 16'd0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [15:0] hold_res;
      logic [15:0] s0, a0, c0;
      int base;
      void'($urandom(32'd20240601));
      for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
      mem[200] = 16'hFFFF;
      mem[201] = 16'h8000;
      mem[202] = 16'h0001;
      start = 0; suspend = 0; init_sum = 0; start_addr = 0; word_count = 0;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R8 reset state
      check("R8 busy", {15'd0, busy}, 16'd0);
      check("R8 done", {15'd0, done}, 16'd0);
      check("R8 req", {15'd0, mem_req}, 16'd0);

      // R5 zero count: done on accepting edge, no read, folded init
      base = req_cnt;
      @(negedge clk);
      init_sum = 16'h1234; word_count = 0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R5 done", {15'd0, done}, 16'd1);
      check("R5 result", result, 16'h1234);
      base = req_cnt - base;
      check("R5 no read", 16'(base), 16'd0);
      kick(16'hFFFF, 0, 0);
      check("R5 R4 fold init", result, 16'h0000);

      // R1 zero sum plus FFFF: no carry, rotate keeps FFFF, R4 folds to 0
      run_check("R1 zero-sum no carry", 16'h0000, 16'd200, 1);
      check("R4 fold", result, 16'h0000);
      // R1 true carry: 0001+FFFF -> 0000 carry -> 0001 -> rot 0002
      run_check("R1 carry", 16'h0001, 16'd200, 1);
      check("R1 value", result, 16'h0002);
      // R2 rotate wraps MSB: 8000 -> 0001
      run_check("R2 rotate", 16'h0000, 16'd201, 1);
      check("R2 value", result, 16'h0001);
      run_check("R1 R2 three", 16'h0000, 16'd200, 3);

      // random blocks
      for (int k = 0; k < 25; k++)
         run_check("R1 random", 16'h0000, 16'($urandom % 200), 1 + int'($urandom % 40));

      // R6 done and result hold
      hold_res = result;
      repeat (5) @(negedge clk);
      check("R6 hold done", {15'd0, done}, 16'd1);
      check("R6 hold result", result, hold_res);

      // R6 start while busy ignored
      kick(16'h0000, 16'd10, 16'd20);
      repeat (2) @(negedge clk);
      init_sum = 16'h5555; start_addr = 16'd90; word_count = 16'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_stop();
      check("R6 busy start ignored", result, ref_fold(ref_run(16'h0000, 16'd10, 20)));

      // R7 suspend after the first word, then resume
      suspend = 1'b1;
      kick(16'h0000, 16'd40, 16'd12);
      wait_stop();
      suspend = 1'b0;
      check("R7 suspended", {15'd0, suspended}, 16'd1);
      check("R7 busy low", {15'd0, busy}, 16'd0);
      check("R9 count", cur_count, 16'd11);
      check("R9 addr", cur_addr, 16'd41);
      check("R9 sum", cur_sum, ref_run(16'h0000, 16'd40, 1));
      s0 = cur_sum; a0 = cur_addr; c0 = cur_count;
      kick(s0, a0, c0);
      wait_stop();
      check("R7 resumed result", result, ref_fold(ref_run(16'h0000, 16'd40, 12)));

      // R7 suspend raised mid-run
      kick(16'h0000, 16'd100, 16'd30);
      repeat (15) @(negedge clk);
      suspend = 1'b1;
      wait_stop();
      suspend = 1'b0;
      check("R7 mid suspended", {15'd0, suspended}, 16'd1);
      s0 = cur_sum; a0 = cur_addr; c0 = cur_count;
      check("R9 mid sum", s0, ref_run(16'h0000, 16'd100, 30 - int'(c0)));
      kick(s0, a0, c0);
      wait_stop();
      check("R7 mid resumed", result, ref_fold(ref_run(16'h0000, 16'd100, 30)));

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule